// File: doc/BRIEF.md
# Serial ADC Output Frame Generator

This block is the digital side of a two-channel 10-bit successive-approximation converter, seen from its 3-wire serial port. It watches an active-low select pin and a serial clock, takes conversion results from a behavioural stand-in for the converter core, and drives a tri-stateable serial data line. Both pins are assumed to be already synchronous to the system clock `clk_i`. Every edge of either pin is detected one system clock after it arrives.

On each falling edge of select, the level of the serial clock picks one of two timing modes. In the serially clocked mode the host clock paces the conversion. The result is captured on the second falling serial edge. In the self-timed mode the first falling serial edge captures the result and starts an internally timed conversion. That timing is modelled as a system clock divided by `OSC_DIV` and run for `CONV_LEN` divided cycles. The data line rises by itself when the conversion ends. The converted channel alternates with every select cycle. Each 12-bit code input carries 10 data bits in bits [11:2] and two sub-LSB bits in bits [1:0].

Top module: `adc_serial_frame`

## Requirements
- R1: While `cs_ni` is high the block is shut down. One clock after `cs_ni` is sampled high, `dout_oe_o` is 0 and `dout_o` is 0. One clock after `cs_ni` is sampled low, `dout_oe_o` is 1.
- R2: A falling edge of `cs_ni` with `sclk_i` high selects the self-timed mode, in which the first falling serial edge leaves `dout_o` at 0. A falling edge of `cs_ni` with `sclk_i` low selects the serially clocked mode, in which the first falling serial edge drives `dout_o` to 1.
- R3: The first select cycle after reset converts channel 0 (`ch0_code_i`). Every later falling edge of `cs_ni` switches to the other channel, and this includes cycles that were aborted. The channel-ID frame bit is 0 for channel 0 and 1 for channel 1.
- R4: In the serially clocked mode, falling serial edges 1 to 16 present, in order: 1, 1, 1, channel ID, code bits 11 down to 2, code bit 1, code bit 0.
- R5: After the 16th frame bit, each further falling serial edge with `cs_ni` low presents 0.
- R6: In the serially clocked mode, the selected code input is captured at the second falling serial edge. Changes to the input before that edge appear in the frame, and changes after it do not.
- R7: In the self-timed mode, the first falling serial edge captures the code and starts a conversion lasting `OSC_DIV*CONV_LEN` clocks. During the conversion `dout_o` stays 0 and serial edges are ignored. At the end `dout_o` rises to 1 (end of conversion) with no serial edge.
- R8: In the self-timed mode, after end of conversion, falling serial edges present frame bits 2 to 16: 1, 1, channel ID, code bits 11 down to 0.
- R9: Raising `cs_ni` before the conversion completes aborts it. A following self-timed cycle stays at 0 until its own first falling serial edge, however long that edge is delayed.
- R10: With `cs_ni` low, `dout_o` changes only in the clock after a detected falling serial edge, or at end of conversion.

Parameters: `RES_W` (10), `SUB_W` (2), `LEAD_ONES` (3), `OSC_DIV` (4), `CONV_LEN` (12).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low select; high means shutdown |
| sclk_i | input | 1 | Serial clock |
| ch0_code_i | input | RES_W+SUB_W | Stand-in result for channel 0 |
| ch1_code_i | input | RES_W+SUB_W | Stand-in result for channel 1 |
| dout_o | output | 1 | Serial data, 0 when not enabled |
| dout_oe_o | output | 1 | Output enable for the data line tri-state |

## Verification
The hardest situation to reach from the ports is the self-timed conversion window. It must be shown that serial edges arriving mid-conversion neither advance the frame nor end it early, and that an abort leaves no stale end-of-conversion behind. The stimulus toggles the serial clock twice while the conversion is busy, then reads the full frame and requires every bit in place. A separate cycle aborts a conversion and then holds a new self-timed select low for longer than a conversion without any serial edge, requiring the line to stay low. The second-edge capture point is reached by changing the code inputs between the first and second pulses and again after the second.

// File: rtl/adc_sf_pkg.sv
`timescale 1ns/1ps
package adc_sf_pkg;
  typedef enum logic {MODE_EXT = 1'b0, MODE_INT = 1'b1} clk_mode_e;
  typedef enum logic [1:0] {ST_OFF, ST_ARMED, ST_CONV, ST_SHIFT} sf_state_e;
endpackage

// File: rtl/adc_sf_edges.sv
`timescale 1ns/1ps
module adc_sf_edges (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  output logic cs_fall_o,
  output logic sclk_fall_o
);
  logic cs_q, sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_ni;
      sclk_q <= sclk_i;
    end
  end

  assign cs_fall_o   = cs_q & ~cs_ni;
  assign sclk_fall_o = sclk_q & ~sclk_i;
endmodule

// File: rtl/adc_sf_conv_timer.sv
`timescale 1ns/1ps
module adc_sf_conv_timer #(
  parameter int OSC_DIV  = 4,
  parameter int CONV_LEN = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic busy_o,
  output logic done_o
);
  localparam int DIV_W = $clog2(OSC_DIV + 1);
  localparam int LEN_W = $clog2(CONV_LEN + 1);

  logic [DIV_W-1:0] div_q;
  logic [LEN_W-1:0] osc_q;
  logic             busy_q;
  logic             div_wrap;

  assign div_wrap = (div_q == DIV_W'(OSC_DIV - 1));
  assign done_o   = busy_q && div_wrap && (osc_q == LEN_W'(CONV_LEN - 1));
  assign busy_o   = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      div_q  <= '0;
      osc_q  <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      div_q  <= '0;
      osc_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      div_q  <= '0;
      osc_q  <= '0;
    end else if (busy_q) begin
      if (div_wrap) begin
        div_q <= '0;
        if (done_o) busy_q <= 1'b0;
        else        osc_q  <= osc_q + 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_sf_shifter.sv
`timescale 1ns/1ps
module adc_sf_shifter #(
  parameter int RES_W     = 10,
  parameter int SUB_W     = 2,
  parameter int LEAD_ONES = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   eoc_i,
  input  logic                   adv_i,
  input  logic                   cap_i,
  input  logic                   chan_i,
  input  logic [RES_W+SUB_W-1:0] code_i,
  output logic                   at_one_o,
  output logic                   bit_o
);
  localparam int CODE_W  = RES_W + SUB_W;
  localparam int FRAME_W = LEAD_ONES + 1 + CODE_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);

  logic [CNT_W-1:0]   cnt_q;
  logic               chid_q;
  logic [CODE_W-1:0]  code_q;
  logic [FRAME_W-1:0] frame;

  assign frame    = {{LEAD_ONES{1'b1}}, chid_q, code_q};
  assign at_one_o = (cnt_q == CNT_W'(1));

  // cnt_q = number of frame bits already presented; past FRAME_W the line idles at 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    cnt_q <= '0;
    else if (clr_i)                                 cnt_q <= '0;
    else if (eoc_i)                                 cnt_q <= CNT_W'(1);
    else if (adv_i && cnt_q != CNT_W'(FRAME_W + 1)) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chid_q <= 1'b0;
      code_q <= '0;
    end else if (cap_i) begin
      chid_q <= chan_i;
      code_q <= code_i;
    end
  end

  always_comb begin
    bit_o = 1'b0;
    for (int k = 1; k <= FRAME_W; k++)
      if (cnt_q == CNT_W'(k)) bit_o = frame[FRAME_W-k];
  end
endmodule

// File: rtl/adc_serial_frame.sv
`timescale 1ns/1ps
module adc_serial_frame #(
  parameter int RES_W     = 10,
  parameter int SUB_W     = 2,
  parameter int LEAD_ONES = 3,
  parameter int OSC_DIV   = 4,
  parameter int CONV_LEN  = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cs_ni,
  input  logic                   sclk_i,
  input  logic [RES_W+SUB_W-1:0] ch0_code_i,
  input  logic [RES_W+SUB_W-1:0] ch1_code_i,
  output logic                   dout_o,
  output logic                   dout_oe_o
);
  import adc_sf_pkg::*;

  localparam int CODE_W = RES_W + SUB_W;

  sf_state_e   state_q;
  clk_mode_e   mode_q;
  logic        chan_q, next_chan_q, oe_q;
  logic        cs_fall, sclk_fall;
  logic        conv_start, conv_busy, conv_done;
  logic        cap, adv, eoc, at_one, frame_bit;
  logic [CODE_W-1:0] code_sel;

  adc_sf_edges u_edges (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .sclk_i     (sclk_i),
    .cs_fall_o  (cs_fall),
    .sclk_fall_o(sclk_fall)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_OFF;
      mode_q      <= MODE_EXT;
      chan_q      <= 1'b0;
      next_chan_q <= 1'b0;
      oe_q        <= 1'b0;
    end else begin
      oe_q <= ~cs_ni;
      if (cs_ni) begin
        state_q <= ST_OFF;
      end else begin
        unique case (state_q)
          ST_OFF: if (cs_fall) begin
            mode_q      <= sclk_i ? MODE_INT : MODE_EXT;
            chan_q      <= next_chan_q;
            next_chan_q <= ~next_chan_q;
            state_q     <= sclk_i ? ST_ARMED : ST_SHIFT;
          end
          ST_ARMED: if (sclk_fall) state_q <= ST_CONV;
          ST_CONV:  if (conv_done) state_q <= ST_SHIFT;
          default:  ;
        endcase
      end
    end
  end

  assign conv_start = (state_q == ST_ARMED) && sclk_fall;
  assign eoc        = (state_q == ST_CONV) && conv_done;
  assign adv        = (state_q == ST_SHIFT) && sclk_fall;
  // external mode samples on the second falling serial edge
  assign cap        = conv_start || (adv && mode_q == MODE_EXT && at_one);
  assign code_sel   = chan_q ? ch1_code_i : ch0_code_i;

  adc_sf_conv_timer #(
    .OSC_DIV (OSC_DIV),
    .CONV_LEN(CONV_LEN)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(conv_start),
    .abort_i(cs_ni),
    .busy_o (conv_busy),
    .done_o (conv_done)
  );

  adc_sf_shifter #(
    .RES_W    (RES_W),
    .SUB_W    (SUB_W),
    .LEAD_ONES(LEAD_ONES)
  ) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cs_ni),
    .eoc_i   (eoc),
    .adv_i   (adv),
    .cap_i   (cap),
    .chan_i  (chan_q),
    .code_i  (code_sel),
    .at_one_o(at_one),
    .bit_o   (frame_bit)
  );

  assign dout_oe_o = oe_q;
  assign dout_o    = oe_q & frame_bit;
endmodule

// File: rtl/adc_serial_frame_chk.sv
`timescale 1ns/1ps
module adc_serial_frame_chk (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cs_ni,
  input logic                  dout_o,
  input logic                  dout_oe_o,
  input logic                  sclk_fall,
  input logic                  conv_busy,
  input logic                  conv_done,
  input adc_sf_pkg::clk_mode_e mode_q
);
  import adc_sf_pkg::*;

  assert_shutdown_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni)) |-> (!dout_oe_o && !dout_o));

  assert_busy_self_timed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_busy |-> (mode_q == MODE_INT));

  assert_busy_line_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_busy |-> !dout_o);

  assert_eoc_rises_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_done && !cs_ni) |=> dout_o);

  assert_abort_stops_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !conv_busy);

  assert_change_on_fall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !$past(cs_ni) && !$past(cs_ni, 2) && !$past(sclk_fall) && !$past(conv_done))
      |-> $stable(dout_o));
endmodule

bind adc_serial_frame adc_serial_frame_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_ni    (cs_ni),
  .dout_o   (dout_o),
  .dout_oe_o(dout_oe_o),
  .sclk_fall(sclk_fall),
  .conv_busy(conv_busy),
  .conv_done(conv_done),
  .mode_q   (mode_q)
);

// File: tb/adc_serial_frame_test.sv
`timescale 1ns/1ps
module adc_serial_frame_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic [11:0] ch0 = '0;
  logic [11:0] ch1 = '0;
  logic        dout, dout_oe;
  int          n_chk = 0;
  int          n_err = 0;
  logic        exp_chan = 1'b0;

  always #2.5 clk = ~clk;

  adc_serial_frame uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cs_ni     (cs_n),
    .sclk_i    (sclk),
    .ch0_code_i(ch0),
    .ch1_code_i(ch1),
    .dout_o    (dout),
    .dout_oe_o (dout_oe)
  );

  // {self_timed, ch0 code, ch1 code}
  localparam logic [24:0] VEC [6] = '{
    {1'b0, 12'hABC, 12'h123},
    {1'b0, 12'h555, 12'hFFF},
    {1'b1, 12'h000, 12'hA5A},
    {1'b1, 12'hFFF, 12'h3C3},
    {1'b0, 12'h800, 12'h001},
    {1'b1, 12'h7FE, 12'h400}
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  function automatic logic exp_bit(input int k, input logic chid, input logic [11:0] code);
    if (k <= 3)  return 1'b1;
    if (k == 4)  return chid;
    if (k <= 16) return code[16-k];
    return 1'b0;
  endfunction

  function automatic string tag_of(input int k, input logic self_timed);
    if (k > 16) return "R5";
    if (k == 4) return "R3";
    return self_timed ? "R8" : "R4";
  endfunction

  task automatic cs_start(input logic self_timed);
    sclk = self_timed;
    wait_clk(3);
    cs_n = 1'b0;
    wait_clk(3);
    chk(dout_oe, 1'b1, "R1 enable after select");
    chk(dout, 1'b0, "R1 idle line after select");
    exp_chan = ~exp_chan;
  endtask

  task automatic cs_end();
    cs_n = 1'b1;
    wait_clk(3);
    chk(dout_oe, 1'b0, "R1 disable on deselect");
    chk(dout, 1'b0, "R1 line low on deselect");
    sclk = 1'b0;
    wait_clk(3);
  endtask

  task automatic pulse(input int k, input logic chid, input logic [11:0] code, input logic self_timed);
    sclk = 1'b1;
    wait_clk(3);
    if (k > 1) chk(dout, exp_bit(k-1, chid, code), $sformatf("R10 hold across rise before bit %0d", k));
    sclk = 1'b0;
    wait_clk(3);
    chk(dout, exp_bit(k, chid, code), $sformatf("%s bit %0d", tag_of(k, self_timed), k));
  endtask

  // first falling edge plus conversion; optionally poke sclk while busy
  task automatic self_timed_start(input int pokes);
    sclk = 1'b0;
    wait_clk(3);
    chk(dout, 1'b0, "R2 R7 line low after first edge");
    for (int p = 0; p < pokes; p++) begin
      sclk = 1'b1; wait_clk(3);
      sclk = 1'b0; wait_clk(3);
      chk(dout, 1'b0, "R7 serial edge ignored while busy");
    end
    wait_clk(60);
    chk(dout, 1'b1, "R7 end of conversion");
  endtask

  task automatic run_frame(input logic self_timed, input logic [11:0] c0, input logic [11:0] c1,
                           input int trail, input int idle);
    logic        chid;
    logic [11:0] code;
    ch0  = c0;
    ch1  = c1;
    chid = exp_chan;
    code = exp_chan ? c1 : c0;
    cs_start(self_timed);
    if (idle > 0) begin
      wait_clk(idle);
      chk(dout, 1'b0, "R9 no stale conversion before first edge");
    end
    if (self_timed) begin
      self_timed_start(0);
      for (int k = 2; k <= 16 + trail; k++) pulse(k, chid, code, 1'b1);
    end else begin
      for (int k = 1; k <= 16 + trail; k++) pulse(k, chid, code, 1'b0);
    end
    cs_end();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [11:0] code_b;
    logic        chid;
    wait_clk(5);
    chk(dout_oe, 1'b0, "R1 enable low in reset");
    chk(dout, 1'b0, "R1 line low in reset");
    rst_n = 1'b1;
    wait_clk(3);
    chk(dout_oe, 1'b0, "R1 enable low after reset");

    // table walk: channel alternates from channel 0
    for (int v = 0; v < 6; v++)
      run_frame(VEC[v][24], VEC[v][23:12], VEC[v][11:0], 0, 0);

    // R5: trailing zeros
    run_frame(1'b0, 12'hFFF, 12'hFFF, 3, 0);
    run_frame(1'b1, 12'hFFF, 12'hFFF, 2, 0);

    // R6: capture at second falling edge
    chid = exp_chan;
    ch0 = 12'h111; ch1 = 12'h111;
    cs_start(1'b0);
    pulse(1, chid, 12'h000, 1'b0);
    code_b = 12'hD2B;
    ch0 = code_b; ch1 = code_b;
    pulse(2, chid, code_b, 1'b0);
    ch0 = 12'h2D4; ch1 = 12'h2D4;
    for (int k = 3; k <= 16; k++) begin
      pulse(k, chid, code_b, 1'b0);
      if (k == 16) chk(dout, code_b[0], "R6 last bit from second-edge sample");
    end
    cs_end();

    // R7: serial edges during conversion are ignored
    chid = exp_chan;
    ch0 = 12'h6A9; ch1 = 12'h6A9;
    cs_start(1'b1);
    self_timed_start(2);
    for (int k = 2; k <= 16; k++) pulse(k, chid, 12'h6A9, 1'b1);
    cs_end();

    // R9: abort mid conversion, then a long idle self-timed cycle
    cs_start(1'b1);
    sclk = 1'b0;
    wait_clk(10);
    chk(dout, 1'b0, "R9 line low before abort");
    cs_end();
    run_frame(1'b1, 12'h0F0, 12'h90F, 0, 70);

    // R3: abort in external mode still advances the channel
    cs_start(1'b0);
    pulse(1, 1'b0, 12'h000, 1'b0);
    cs_end();
    run_frame(1'b0, 12'h3A5, 12'hC5A, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule